// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers the reset causes of a small processor chip: power-on, an illegal opcode, an opcode fetch from an unmapped address, and a low-voltage warning. It records each cause in a sticky status register. It then drives the reset release in a fixed order. First the external reset pin is held low for a long count of reference clocks. Next the CPU is kept in reset for two shorter phases. Finally the two reset-vector addresses are presented on consecutive cycles.

Whether a source counts depends on what the CPU is doing. An unmapped address causes a reset only on an opcode fetch. A stop instruction is an illegal opcode only when stopping is disabled. A prefix byte followed by the stop opcode on the next opcode fetch is also trapped. A low-voltage warning only has an effect when both low-voltage enables are set. In that case the reset pin stays low for as long as the warning lasts, and the long count starts once the supply has recovered. A source that fires during a sequence restarts the sequence from the start of the long count. Software reads the status register through a read strobe, and the read clears it.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high, `status_o` is 4'b1000, the pin drive is low and the CPU is in reset. The pin drive stays low for HOLD_CYCLES rising edges after `por_i` falls. Status bit 3 is the power-on cause.
- R2: Once the pin drive rises, `cpu_rst_o` stays high for another 2*PHASE_CYCLES cycles.
- R3: In the cycle `cpu_rst_o` falls, `vec_fetch_o` is high with `vec_addr_o` = 16'hFFFE. In the next cycle it is high with 16'hFFFF. After that it is low.
- R4: `illop_i` sets status bit 2 (illegal opcode) and restarts the sequence at the long hold, starting with the next cycle.
- R5: With `stop_en_i` = 0, `stop_i` acts like `illop_i`. With `stop_en_i` = 1 it has no effect on the outputs or the status.
- R6: An opcode fetch of 8'h9E followed by an opcode fetch of 8'h8E as the next opcode fetch sets bit 2 and starts a reset. 8'h8E after any other fetched byte has no effect.
- R7: `unmapped_i` together with `opc_fetch_i` sets status bit 1 (illegal address) and starts a reset. Without `opc_fetch_i` it has no effect.
- R8: With `lv_pwr_en_i` and `lv_rst_en_i` both 1, `lv_flag_i` sets status bit 0 and holds the pin drive low while it is high. The full sequence then follows, starting when the flag falls. If either enable is 0, the flag has no effect.
- R9: A non-power-on reset clears bit 3 and sets its own bit. Sources firing in the same cycle set all of their bits.
- R10: A cycle with `status_rd_i` high clears the status, except for the bits that sources set in that same cycle.
- R11: A source that fires during an ongoing sequence drives the pin low again and restarts the full hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_i | input | 1 | Power-on pulse, asynchronous, active high |
| lv_flag_i | input | 1 | Low-supply comparator flag |
| opc_fetch_i | input | 1 | CPU bus cycle is an opcode fetch |
| opcode_i | input | 8 | Byte fetched in the opcode fetch |
| illop_i | input | 1 | CPU decoded an illegal opcode |
| stop_i | input | 1 | CPU decoded a stop instruction |
| unmapped_i | input | 1 | Current access hits no mapped address |
| stop_en_i | input | 1 | Configuration: stop instruction allowed |
| lv_pwr_en_i | input | 1 | Configuration: low-voltage monitor powered |
| lv_rst_en_i | input | 1 | Configuration: low-voltage reset enabled |
| status_rd_i | input | 1 | Status read strobe (clears on read) |
| rst_pin_n_o | output | 1 | External reset pin drive, low = reset |
| cpu_rst_o | output | 1 | Internal CPU reset, high = reset |
| vec_fetch_o | output | 1 | Reset-vector fetch in progress |
| vec_addr_o | output | 16 | Vector fetch address |
| status_o | output | 4 | Sticky reset causes {por, ilop, ilad, lv} |

## Verification
The bench builds the block with HOLD_CYCLES = 16 and PHASE_CYCLES = 4, so a full release sequence is 26 cycles instead of several thousand. This keeps many complete sequences, restarts at different points and low-voltage holds within a short run. Every phase boundary is compared cycle by cycle against a queue computed from those two values. It also brings within reach a restart during the CPU-release phases, after the pin has already risen.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_LVWAIT,
        ST_HOLD,
        ST_PH1,
        ST_PH2,
        ST_VEC0,
        ST_VEC1,
        ST_RUN
    } seq_state_e;

    localparam int STAT_W = 4;
    localparam int B_LV   = 0;
    localparam int B_ILAD = 1;
    localparam int B_ILOP = 2;
    localparam int B_POR  = 3;

    localparam int OPC_W  = 8;
    localparam int ADDR_W = 16;

    localparam logic [OPC_W-1:0]  OP_PREFIX = 8'h9E;
    localparam logic [OPC_W-1:0]  OP_STOP   = 8'h8E;
    localparam logic [ADDR_W-1:0] VEC_FIRST = 16'hFFFE;
    localparam logic [ADDR_W-1:0] VEC_SECOND = 16'hFFFF;

    typedef struct packed {
        logic illop;
        logic ilad;
        logic lv;
    } src_ev_t;

endpackage

// File: rtl/rstseq_detect.sv
module rstseq_detect
    import rstseq_pkg::*;
(
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             opc_fetch_i,
    input  logic [OPC_W-1:0] opcode_i,
    input  logic             illop_i,
    input  logic             stop_i,
    input  logic             unmapped_i,
    input  logic             stop_en_i,
    input  logic             lv_flag_i,
    input  logic             lv_pwr_en_i,
    input  logic             lv_rst_en_i,
    output src_ev_t          ev_o
);

    typedef struct packed {
        logic prefix;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (opc_fetch_i) begin
            det_d.prefix = (opcode_i == OP_PREFIX);
        end
        ev_o.illop = illop_i
                   | (stop_i & ~stop_en_i)
                   | (opc_fetch_i & det_q.prefix & (opcode_i == OP_STOP));
        ev_o.ilad  = unmapped_i & opc_fetch_i;
        ev_o.lv    = lv_flag_i & lv_pwr_en_i & lv_rst_en_i;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              rd_i,
    input  src_ev_t           ev_i,
    output logic [STAT_W-1:0] status_o
);

    logic [STAT_W-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = rd_i ? '0 : stat_q;
        if (ev_i.illop) stat_d[B_ILOP] = 1'b1;
        if (ev_i.ilad)  stat_d[B_ILAD] = 1'b1;
        if (ev_i.lv)    stat_d[B_LV]   = 1'b1;
        if (|ev_i)      stat_d[B_POR]  = 1'b0;
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            stat_q <= STAT_W'(1) << B_POR;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status_o = stat_q;

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYCLES  = 4096,
    parameter int PHASE_CYCLES = 32
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  src_ev_t           ev_i,
    output logic              rst_pin_n_o,
    output logic              cpu_rst_o,
    output logic              vec_fetch_o,
    output logic [ADDR_W-1:0] vec_addr_o
);

    localparam int MAX_CNT = (HOLD_CYCLES > PHASE_CYCLES) ? HOLD_CYCLES : PHASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(PHASE_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_LVWAIT: begin
                if (!ev_i.lv) begin
                    seq_d.st  = ST_HOLD;
                    seq_d.cnt = '0;
                end
            end
            ST_HOLD: begin
                if (seq_q.cnt == HOLD_LAST) begin
                    seq_d.st  = ST_PH1;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_PH1: begin
                if (seq_q.cnt == PHASE_LAST) begin
                    seq_d.st  = ST_PH2;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_PH2: begin
                if (seq_q.cnt == PHASE_LAST) begin
                    seq_d.st  = ST_VEC0;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_VEC0: seq_d.st = ST_VEC1;
            ST_VEC1: seq_d.st = ST_RUN;
            default: seq_d.st = ST_RUN;
        endcase

        if (ev_i.lv) begin
            seq_d.st  = ST_LVWAIT;
            seq_d.cnt = '0;
        end else if (ev_i.illop || ev_i.ilad) begin
            seq_d.st  = ST_HOLD;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            seq_q.st  <= ST_HOLD;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        rst_pin_n_o = !(seq_q.st == ST_LVWAIT || seq_q.st == ST_HOLD);
        cpu_rst_o   = (seq_q.st == ST_LVWAIT) || (seq_q.st == ST_HOLD)
                   || (seq_q.st == ST_PH1) || (seq_q.st == ST_PH2);
        vec_fetch_o = (seq_q.st == ST_VEC0) || (seq_q.st == ST_VEC1);
        unique case (seq_q.st)
            ST_VEC0: vec_addr_o = VEC_FIRST;
            ST_VEC1: vec_addr_o = VEC_SECOND;
            default: vec_addr_o = '0;
        endcase
    end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int HOLD_CYCLES  = 4096,
    parameter int PHASE_CYCLES = 32
) (
    input  logic         clk_i,
    input  logic         por_i,
    input  logic         lv_flag_i,
    input  logic         opc_fetch_i,
    input  logic [7:0]   opcode_i,
    input  logic         illop_i,
    input  logic         stop_i,
    input  logic         unmapped_i,
    input  logic         stop_en_i,
    input  logic         lv_pwr_en_i,
    input  logic         lv_rst_en_i,
    input  logic         status_rd_i,
    output logic         rst_pin_n_o,
    output logic         cpu_rst_o,
    output logic         vec_fetch_o,
    output logic [15:0]  vec_addr_o,
    output logic [3:0]   status_o
);

    src_ev_t ev;

    rstseq_detect u_detect (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .opc_fetch_i (opc_fetch_i),
        .opcode_i    (opcode_i),
        .illop_i     (illop_i),
        .stop_i      (stop_i),
        .unmapped_i  (unmapped_i),
        .stop_en_i   (stop_en_i),
        .lv_flag_i   (lv_flag_i),
        .lv_pwr_en_i (lv_pwr_en_i),
        .lv_rst_en_i (lv_rst_en_i),
        .ev_o        (ev)
    );

    rstseq_status u_status (
        .clk_i    (clk_i),
        .por_i    (por_i),
        .rd_i     (status_rd_i),
        .ev_i     (ev),
        .status_o (status_o)
    );

    rstseq_timer #(
        .HOLD_CYCLES  (HOLD_CYCLES),
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_timer (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .ev_i        (ev),
        .rst_pin_n_o (rst_pin_n_o),
        .cpu_rst_o   (cpu_rst_o),
        .vec_fetch_o (vec_fetch_o),
        .vec_addr_o  (vec_addr_o)
    );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
    input logic        clk_i,
    input logic        por_i,
    input logic        lv_flag_i,
    input logic        opc_fetch_i,
    input logic        illop_i,
    input logic        stop_i,
    input logic        unmapped_i,
    input logic        lv_pwr_en_i,
    input logic        lv_rst_en_i,
    input logic        status_rd_i,
    input logic        rst_pin_n_o,
    input logic        cpu_rst_o,
    input logic        vec_fetch_o,
    input logic [15:0] vec_addr_o,
    input logic [3:0]  status_o
);

    // R2
    pin_low_cpu_held_chk: assert property (@(posedge clk_i) disable iff (por_i)
        !rst_pin_n_o |-> cpu_rst_o);

    // R3
    vec_start_chk: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(cpu_rst_o) |-> (vec_fetch_o && vec_addr_o == 16'hFFFE));

    // R3
    vec_order_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (vec_fetch_o && vec_addr_o == 16'hFFFE && !illop_i && !stop_i && !unmapped_i && !lv_flag_i)
        |=> (vec_fetch_o && vec_addr_o == 16'hFFFF));

    // R4
    illop_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
        illop_i |=> (!rst_pin_n_o && status_o[2]));

    // R7
    ilad_fetch_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (unmapped_i && opc_fetch_i) |=> (!rst_pin_n_o && status_o[1]));

    // R7
    ilad_data_quiet_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (unmapped_i && !opc_fetch_i && !illop_i && !stop_i && !lv_flag_i && rst_pin_n_o)
        |=> rst_pin_n_o);

    // R8
    lv_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (lv_flag_i && lv_pwr_en_i && lv_rst_en_i) |=> (!rst_pin_n_o && status_o[0]));

    // R10
    read_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (status_rd_i && !illop_i && !stop_i && !unmapped_i && !lv_flag_i && !opc_fetch_i)
        |=> (status_o == 4'b0000));

endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .lv_flag_i   (lv_flag_i),
    .opc_fetch_i (opc_fetch_i),
    .illop_i     (illop_i),
    .stop_i      (stop_i),
    .unmapped_i  (unmapped_i),
    .lv_pwr_en_i (lv_pwr_en_i),
    .lv_rst_en_i (lv_rst_en_i),
    .status_rd_i (status_rd_i),
    .rst_pin_n_o (rst_pin_n_o),
    .cpu_rst_o   (cpu_rst_o),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o),
    .status_o    (status_o)
);

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;

    localparam int HOLD    = 16;
    localparam int PHASE   = 4;
    localparam int SEQ_LEN = HOLD + 2 * PHASE + 4;

    logic        clk = 1'b0;
    logic        por, lv_flag, opc_fetch, illop, stop, unmapped;
    logic        stop_en, lv_pwr_en, lv_rst_en, status_rd;
    logic [7:0]  opcode;
    logic        rst_pin_n, cpu_rst, vec_fetch;
    logic [15:0] vec_addr;
    logic [3:0]  status;

    always #10 clk = ~clk;

    rstseq_top #(.HOLD_CYCLES(HOLD), .PHASE_CYCLES(PHASE)) u_dut (
        .clk_i       (clk),
        .por_i       (por),
        .lv_flag_i   (lv_flag),
        .opc_fetch_i (opc_fetch),
        .opcode_i    (opcode),
        .illop_i     (illop),
        .stop_i      (stop),
        .unmapped_i  (unmapped),
        .stop_en_i   (stop_en),
        .lv_pwr_en_i (lv_pwr_en),
        .lv_rst_en_i (lv_rst_en),
        .status_rd_i (status_rd),
        .rst_pin_n_o (rst_pin_n),
        .cpu_rst_o   (cpu_rst),
        .vec_fetch_o (vec_fetch),
        .vec_addr_o  (vec_addr),
        .status_o    (status)
    );

    typedef struct {
        logic        pin_n;
        logic        cpu;
        logic        vf;
        logic [15:0] addr;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    function automatic exp_t exp_at(int k);
        exp_t e;
        e.vf = 1'b0; e.addr = 16'h0000;
        if (k < HOLD) begin
            e.pin_n = 1'b0; e.cpu = 1'b1; e.req = "R1";
        end else if (k < HOLD + 2 * PHASE) begin
            e.pin_n = 1'b1; e.cpu = 1'b1; e.req = "R2";
        end else if (k == HOLD + 2 * PHASE) begin
            e.pin_n = 1'b1; e.cpu = 1'b0; e.vf = 1'b1; e.addr = 16'hFFFE; e.req = "R3";
        end else if (k == HOLD + 2 * PHASE + 1) begin
            e.pin_n = 1'b1; e.cpu = 1'b0; e.vf = 1'b1; e.addr = 16'hFFFF; e.req = "R3";
        end else begin
            e.pin_n = 1'b1; e.cpu = 1'b0; e.req = "R3";
        end
        return e;
    endfunction

    task automatic push_seq(input int start);
        for (int k = start; k < SEQ_LEN; k++) exp_q.push_back(exp_at(k));
    endtask

    // Monitor: pops one expected item per cycle and compares.
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0 && !done) begin
            e = exp_q.pop_front();
            n_cmp++;
            if (rst_pin_n !== e.pin_n || cpu_rst !== e.cpu || vec_fetch !== e.vf
                || (e.vf && vec_addr !== e.addr)) begin
                n_bad++;
                $display("FAIL %s: actual pin=%b cpu=%b vf=%b addr=%h expected pin=%b cpu=%b vf=%b addr=%h",
                         e.req, rst_pin_n, cpu_rst, vec_fetch, vec_addr,
                         e.pin_n, e.cpu, e.vf, e.addr);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic strobe(input logic il, input logic st, input logic um, input logic of,
                          input logic [7:0] op, input logic rd, input bit expect_rst);
        @(negedge clk);
        illop = il; stop = st; unmapped = um; opc_fetch = of; opcode = op; status_rd = rd;
        @(posedge clk);
        if (expect_rst) begin
            exp_q.delete();
            push_seq(0);
        end
        @(negedge clk);
        illop = 0; stop = 0; unmapped = 0; opc_fetch = 0; opcode = 8'h00; status_rd = 0;
    endtask

    task automatic wait_done();
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic read_clear();
        strobe(0, 0, 0, 0, 8'h00, 1, 0);
        check("R10 read clears", {28'd0, status}, 32'h0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        por = 1; lv_flag = 0; opc_fetch = 0; opcode = 8'h00; illop = 0; stop = 0;
        unmapped = 0; stop_en = 1; lv_pwr_en = 1; lv_rst_en = 1; status_rd = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pin", {31'd0, rst_pin_n}, 32'h0);
        check("R1 cpu", {31'd0, cpu_rst}, 32'h1);
        check("R1 status", {28'd0, status}, 32'h8);
        por = 0;
        @(posedge clk);
        push_seq(1);
        wait_done();
        check("R1 status after", {28'd0, status}, 32'h8);

        // R4 / R9: illegal opcode clears POR bit
        strobe(1, 0, 0, 0, 8'h00, 0, 1);
        check("R4 R9 status", {28'd0, status}, 32'h4);
        wait_done();
        read_clear();

        // R5: stop enabled has no effect, disabled traps
        strobe(0, 1, 0, 0, 8'h00, 0, 0);
        check("R5 pin", {31'd0, rst_pin_n}, 32'h1);
        check("R5 status", {28'd0, status}, 32'h0);
        stop_en = 0;
        strobe(0, 1, 0, 0, 8'h00, 0, 1);
        check("R5 trap status", {28'd0, status}, 32'h4);
        wait_done();
        stop_en = 1;
        read_clear();

        // R6: prefix broken by another fetch, then a real pair
        strobe(0, 0, 0, 1, 8'h9E, 0, 0);
        strobe(0, 0, 0, 1, 8'h20, 0, 0);
        strobe(0, 0, 0, 1, 8'h8E, 0, 0);
        check("R6 no pair pin", {31'd0, rst_pin_n}, 32'h1);
        check("R6 no pair status", {28'd0, status}, 32'h0);
        strobe(0, 0, 0, 1, 8'h9E, 0, 0);
        strobe(0, 0, 0, 1, 8'h8E, 0, 1);
        check("R6 pair status", {28'd0, status}, 32'h4);
        wait_done();
        read_clear();

        // R7: data access vs opcode fetch
        strobe(0, 0, 1, 0, 8'h00, 0, 0);
        check("R7 data pin", {31'd0, rst_pin_n}, 32'h1);
        check("R7 data status", {28'd0, status}, 32'h0);
        strobe(0, 0, 1, 1, 8'h20, 0, 1);
        check("R7 fetch status", {28'd0, status}, 32'h2);
        wait_done();

        // R10: read in the same cycle as a new source
        strobe(1, 0, 0, 0, 8'h00, 1, 1);
        check("R10 same cycle", {28'd0, status}, 32'h4);
        wait_done();
        read_clear();

        // R9: simultaneous sources
        strobe(1, 0, 1, 1, 8'h20, 0, 1);
        check("R9 both bits", {28'd0, status}, 32'h6);
        wait_done();
        read_clear();

        // R8: disabled then enabled low-voltage
        lv_rst_en = 0;
        @(negedge clk); lv_flag = 1;
        repeat (3) @(negedge clk);
        check("R8 disabled pin", {31'd0, rst_pin_n}, 32'h1);
        check("R8 disabled status", {28'd0, status}, 32'h0);
        lv_flag = 0; lv_rst_en = 1;
        @(negedge clk); lv_flag = 1;
        repeat (6) @(negedge clk);
        check("R8 hold pin", {31'd0, rst_pin_n}, 32'h0);
        check("R8 hold cpu", {31'd0, cpu_rst}, 32'h1);
        check("R8 status", {28'd0, status}, 32'h1);
        lv_flag = 0;
        @(posedge clk);
        push_seq(0);
        wait_done();
        check("R8 status after", {28'd0, status}, 32'h1);
        read_clear();

        // R11: restart during hold, and during CPU-release phases
        strobe(1, 0, 0, 0, 8'h00, 0, 1);
        repeat (5) @(negedge clk);
        strobe(1, 0, 0, 0, 8'h00, 0, 1);
        wait_done();
        strobe(1, 0, 0, 0, 8'h00, 0, 1);
        repeat (HOLD + 2) @(negedge clk);
        check("R11 in phase pin", {31'd0, rst_pin_n}, 32'h1);
        check("R11 in phase cpu", {31'd0, cpu_rst}, 32'h1);
        strobe(1, 0, 0, 0, 8'h00, 0, 1);
        check("R11 restart pin", {31'd0, rst_pin_n}, 32'h0);
        wait_done();
        read_clear();

        finish_run();
    end

endmodule